// File: doc/BRIEF.md
# PS/2 Keyboard Receiver with Qualified Clock Edges

This block takes the clock and data lines of a PS/2 keyboard, brings both into the system clock domain through a two-stage synchroniser, and assembles 11-bit frames into bytes. Keyboard clock lines often have slow or ringing transitions. A plain edge detector can therefore see extra falling edges, for example on a sluggish rise. For this reason, a falling clock edge is never trusted on sight.

In the default settle mode, a detected fall starts a programmable countdown. When the countdown ends, the synchronised clock is read again. The data bit is taken only if the clock is still low; otherwise the event is dropped and the bit count is left alone. A cruder hold-off mode can be selected instead. In that mode a fall is accepted at once, and any further fall within a fixed window after it is ignored.

A host inhibit input drives an open-drain style enable that holds the clock line low. While it is asserted, the receiver ignores every edge. A frame that stalls part-way returns the receiver to idle with a timeout strobe. Good frames update the output byte with a one-cycle valid strobe. Malformed frames give a one-cycle error strobe and leave the byte untouched.

Top module: `ps2_rx_qual`

## Requirements
- R1: After reset, `byte_valid`, `frame_error`, `timeout_error` and `ps2_clk_drive_low` are 0 and `rx_byte` is 0x00.
- R2: A frame has 11 bits, taken on accepted falling edges in this order: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit (data plus parity hold an odd number of ones), and a stop bit of 1. A good frame pulses `byte_valid` high for exactly one cycle, and in that same cycle `rx_byte` shows the data byte.
- R3: `rx_byte` changes only in a cycle where `byte_valid` is high. It keeps its value across frames that end in an error or a timeout.
- R4: A frame with a start bit of 1, a parity mismatch or a stop bit of 0 pulses `frame_error` for one cycle and does not pulse `byte_valid`.
- R5: In settle mode (`holdoff_mode` = 0), a detected fall is confirmed only if the synchronised clock is still low `settle_cycles`+1 cycles later. A low pulse shorter than that is discarded and the bit count does not advance.
- R6: Rising clock edges, including a rise that bounces low briefly, never advance the bit count.
- R7: In hold-off mode (`holdoff_mode` = 1), a fall is accepted as soon as it is detected. Falls arriving within HOLDOFF_CYCLES cycles after an accepted one are ignored.
- R8: `ps2_clk_drive_low` follows `host_inhibit` one cycle later. While `host_inhibit` is high, no clock edge is accepted.
- R9: If no bit is accepted for TIMEOUT_CYCLES cycles while a frame is partly received, `timeout_error` pulses for one cycle and the receiver returns to waiting for a start bit.
- R10: At most one of `byte_valid`, `frame_error` and `timeout_error` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | Level of the PS/2 clock line (asynchronous) |
| ps2_data_in | input | 1 | Level of the PS/2 data line (asynchronous) |
| host_inhibit | input | 1 | Host request to hold the clock line low |
| holdoff_mode | input | 1 | 0: settle-and-resample qualification, 1: hold-off window |
| settle_cycles | input | SETTLE_W | Settle countdown length in system cycles |
| ps2_clk_drive_low | output | 1 | Open-drain enable: 1 pulls the clock line low |
| rx_byte | output | 8 | Last correctly received data byte |
| byte_valid | output | 1 | One-cycle strobe for a good frame |
| frame_error | output | 1 | One-cycle strobe for a bad start, parity or stop bit |
| timeout_error | output | 1 | One-cycle strobe when a partial frame stalls |

## Verification
The hardest case to reach from the ports is a spurious falling edge inside a valid frame. That edge must be dropped without shifting every later bit by one. The bench models the clock line with short low glitches placed right after real rising edges, and with a bounce immediately after real falling edges. It then checks that the byte still arrives intact, in both qualification modes. The open-drain loop is closed in the bench: the wired-AND of the device clock and the block's own pull-down is fed back. This exercises the inhibit case with the real self-generated fall on the line.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  typedef enum logic {
    QUAL_SETTLE  = 1'b0,
    QUAL_HOLDOFF = 1'b1
  } qual_mode_e;

  typedef enum logic {
    QS_IDLE = 1'b0,
    QS_WAIT = 1'b1
  } qual_state_e;

  localparam int FRAME_BITS = 11;
  localparam int DATA_BITS  = 8;
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ps2rx_qualifier.sv
module ps2rx_qualifier
  import ps2rx_pkg::*;
#(
  parameter int SETTLE_W       = 8,
  parameter int HOLDOFF_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_s,
  input  logic                data_s,
  input  logic                inhibit,
  input  logic                mode,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                bit_strobe,
  output logic                bit_data
);
  localparam int HW = $clog2(HOLDOFF_CYCLES + 1);

  qual_state_e         state_q;
  logic                clk_prev_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [HW-1:0]       hold_q;
  logic                fall;
  qual_mode_e          mode_e;

  assign mode_e = qual_mode_e'(mode);
  assign fall   = clk_prev_q & ~clk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= QS_IDLE;
      clk_prev_q <= 1'b1;
      settle_q   <= '0;
      hold_q     <= '0;
      bit_strobe <= 1'b0;
      bit_data   <= 1'b0;
    end else begin
      clk_prev_q <= clk_s;
      bit_strobe <= 1'b0;
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      case (state_q)
        QS_IDLE: begin
          if (fall && !inhibit && hold_q == '0) begin
            if (mode_e == QUAL_SETTLE) begin
              settle_q <= settle_cycles;
              state_q  <= QS_WAIT;
            end else begin
              bit_strobe <= 1'b1;
              bit_data   <= data_s;
              hold_q     <= HW'(HOLDOFF_CYCLES);
            end
          end
        end
        default: begin
          if (inhibit) begin
            state_q <= QS_IDLE;
          end else if (settle_q == '0) begin
            state_q <= QS_IDLE;
            if (!clk_s) begin
              bit_strobe <= 1'b1;
              bit_data   <= data_s;
            end
          end else begin
            settle_q <= settle_q - 1'b1;
          end
        end
      endcase
    end
  end

  // R8
  inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !bit_strobe);

  // R5
  settle_low_chk: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> !$past(clk_s));
endmodule

// File: rtl/ps2rx_frame.sv
module ps2rx_frame
  import ps2rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_strobe,
  input  logic                 bit_data,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 byte_valid,
  output logic                 frame_error,
  output logic                 timeout_error
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [CW-1:0]           bit_cnt;
  logic [FRAME_BITS-2:0]   shift_q;
  logic [TW-1:0]           idle_q;
  logic [FRAME_BITS-1:0]   full;
  logic                    start_ok, stop_ok, par_ok, last_bit;

  assign full     = {bit_data, shift_q};
  assign start_ok = (full[0] == 1'b0);
  assign stop_ok  = (full[FRAME_BITS-1] == 1'b1);
  assign par_ok   = ^full[DATA_BITS+1:1];
  assign last_bit = (bit_cnt == CW'(FRAME_BITS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt       <= '0;
      shift_q       <= '0;
      idle_q        <= '0;
      rx_byte       <= '0;
      byte_valid    <= 1'b0;
      frame_error   <= 1'b0;
      timeout_error <= 1'b0;
    end else begin
      byte_valid    <= 1'b0;
      frame_error   <= 1'b0;
      timeout_error <= 1'b0;
      if (bit_strobe) begin
        idle_q  <= '0;
        shift_q <= {bit_data, shift_q[FRAME_BITS-2:1]};
        if (last_bit) begin
          bit_cnt <= '0;
          if (start_ok && stop_ok && par_ok) begin
            byte_valid <= 1'b1;
            rx_byte    <= full[DATA_BITS:1];
          end else begin
            frame_error <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (idle_q == TW'(TIMEOUT_CYCLES - 1)) begin
          idle_q        <= '0;
          bit_cnt       <= '0;
          timeout_error <= 1'b1;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end else begin
        idle_q <= '0;
      end
    end
  end

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_valid, frame_error, timeout_error}));

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> byte_valid);

  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_error |-> (bit_cnt == '0));
endmodule

// File: rtl/ps2_rx_qual.sv
module ps2_rx_qual
  import ps2rx_pkg::*;
#(
  parameter int SETTLE_W       = 8,
  parameter int HOLDOFF_CYCLES = 1000,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ps2_clk_in,
  input  logic                 ps2_data_in,
  input  logic                 host_inhibit,
  input  logic                 holdoff_mode,
  input  logic [SETTLE_W-1:0]  settle_cycles,
  output logic                 ps2_clk_drive_low,
  output logic [7:0]           rx_byte,
  output logic                 byte_valid,
  output logic                 frame_error,
  output logic                 timeout_error
);
  logic [1:0] lines_s;
  logic       strobe, sbit;

  ps2rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({ps2_data_in, ps2_clk_in}),
    .sync_out(lines_s)
  );

  ps2rx_qualifier #(.SETTLE_W(SETTLE_W), .HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_qual (
    .clk(clk), .rst(rst),
    .clk_s(lines_s[0]), .data_s(lines_s[1]),
    .inhibit(host_inhibit | ps2_clk_drive_low),
    .mode(holdoff_mode), .settle_cycles(settle_cycles),
    .bit_strobe(strobe), .bit_data(sbit)
  );

  ps2rx_frame #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_frame (
    .clk(clk), .rst(rst),
    .bit_strobe(strobe), .bit_data(sbit),
    .rx_byte(rx_byte), .byte_valid(byte_valid),
    .frame_error(frame_error), .timeout_error(timeout_error)
  );

  always_ff @(posedge clk) begin
    if (rst) ps2_clk_drive_low <= 1'b0;
    else     ps2_clk_drive_low <= host_inhibit;
  end

  // R8
  drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
    host_inhibit |=> ps2_clk_drive_low);
endmodule

// File: tb/ps2_rx_qual_test.sv
module ps2_rx_qual_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 50;
  localparam int SETTLE     = 8;
  localparam int HOLDOFF    = 30;
  localparam int TIMEOUT    = 2000;

  logic clk = 0, rst = 1;
  logic dev_clk = 1, dev_data = 1;
  logic host_inhibit = 0, holdoff_mode = 0;
  logic [7:0] settle_cycles = 8'(SETTLE);
  logic drive_low, byte_valid, frame_error, timeout_error;
  logic [7:0] rx_byte;
  logic ps2_clk_line;

  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct {
    int         kind;
    logic [7:0] held;
    string      req;
  } exp_t;
  exp_t expq[$];

  assign ps2_clk_line = dev_clk & ~drive_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_rx_qual #(.SETTLE_W(8), .HOLDOFF_CYCLES(HOLDOFF), .TIMEOUT_CYCLES(TIMEOUT)) uut (
    .clk(clk), .rst(rst), .ps2_clk_in(ps2_clk_line), .ps2_data_in(dev_data),
    .host_inhibit(host_inhibit), .holdoff_mode(holdoff_mode),
    .settle_cycles(settle_cycles), .ps2_clk_drive_low(drive_low),
    .rx_byte(rx_byte), .byte_valid(byte_valid),
    .frame_error(frame_error), .timeout_error(timeout_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pop expected events when the design strobes
  always @(negedge clk) begin
    if (!rst && (byte_valid || frame_error || timeout_error)) begin
      int kind;
      kind = byte_valid ? 0 : (frame_error ? 1 : 2);
      if (expq.size() == 0) begin
        check(0, "R2/R5/R8 unexpected strobe", kind, -1);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(kind == e.kind, {e.req, " kind"}, kind, e.kind);
        check(rx_byte == e.held, {e.req, " byte"}, rx_byte, e.held);
      end
    end
  end

  function automatic logic [10:0] mkframe(input logic [7:0] d, input bit bad_start,
                                          input bit bad_par, input bit bad_stop);
    logic p;
    p = ~^d ^ bad_par;
    return {~bad_stop, p, d, bad_start};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch_rise: short low pulse after each rising edge; bounce_fall: bounce at each falling edge
  task automatic send_bits(input logic [10:0] bits, input int nbits,
                           input bit glitch_rise, input bit bounce_fall);
    for (int i = 0; i < nbits; i++) begin
      dev_data = bits[i];
      wait_cyc(HALF);
      if (bounce_fall) begin
        dev_clk = 0; wait_cyc(3);
        dev_clk = 1; wait_cyc(3);
        dev_clk = 0; wait_cyc(HALF - 6);
      end else begin
        dev_clk = 0; wait_cyc(HALF);
      end
      dev_clk = 1;
      if (glitch_rise) begin
        wait_cyc(4);
        dev_clk = 0; wait_cyc(3);
        dev_clk = 1;
      end
    end
    dev_data = 1;
  endtask

  logic [7:0] last_good = 8'h00;

  task automatic push(input int kind, input logic [7:0] b, input string req);
    exp_t e;
    e.kind = kind; e.held = b; e.req = req;
    expq.push_back(e);
  endtask

  task automatic good_frame(input logic [7:0] d, input bit gr, input bit bf, input string req);
    last_good = d;
    push(0, d, req);
    send_bits(mkframe(d, 0, 0, 0), 11, gr, bf);
    wait_cyc(HALF);
  endtask

  initial begin
    wait_cyc(4);
    rst = 0;
    wait_cyc(2);
    // R1 reset state
    check(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
    check({byte_valid, frame_error, timeout_error} == 3'b000, "R1 strobes",
          {byte_valid, frame_error, timeout_error}, 0);
    check(drive_low == 0, "R1 drive_low", drive_low, 0);

    // R2 clean frames, settle mode
    good_frame(8'hA5, 0, 0, "R2 A5");
    good_frame(8'h00, 0, 0, "R2 00");
    good_frame(8'hFF, 0, 0, "R2 FF");

    // R4 and R3: errors keep rx_byte
    push(1, last_good, "R4 parity R3");
    send_bits(mkframe(8'h12, 0, 1, 0), 11, 0, 0); wait_cyc(HALF);
    push(1, last_good, "R4 stop R3");
    send_bits(mkframe(8'h34, 0, 0, 1), 11, 0, 0); wait_cyc(HALF);
    push(1, last_good, "R4 start R3");
    send_bits(mkframe(8'h56, 1, 0, 0), 11, 0, 0); wait_cyc(HALF);

    // R5/R6 spurious edges in settle mode
    good_frame(8'h3C, 1, 0, "R6 rise glitch");
    good_frame(8'h96, 0, 1, "R5 fall bounce");
    good_frame(8'h69, 1, 1, "R5 R6 both");

    // R8 inhibit
    host_inhibit = 1;
    wait_cyc(2);
    check(drive_low == 1, "R8 drive_low set", drive_low, 1);
    wait_cyc(200);
    host_inhibit = 0;
    wait_cyc(2);
    check(drive_low == 0, "R8 drive_low clear", drive_low, 0);
    wait_cyc(HALF);
    good_frame(8'h81, 0, 0, "R8 after inhibit");

    // R9 timeout then recovery
    push(2, last_good, "R9 timeout");
    send_bits(mkframe(8'hE7, 0, 0, 0), 4, 0, 0);
    wait_cyc(TIMEOUT + 200);
    good_frame(8'h5A, 0, 0, "R9 recover");

    // R7 hold-off mode with bounce at each fall
    holdoff_mode = 1;
    wait_cyc(HALF);
    good_frame(8'hC3, 0, 1, "R7 holdoff bounce");
    good_frame(8'h2B, 0, 0, "R7 holdoff clean");

    wait_cyc(20);
    check(expq.size() == 0, "R2 all expected events seen", expq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule